// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves data from a source address range to a destination range over a simple memory bus. It does one read followed by one write for every beat. A start pulse captures a set of configuration inputs, which stay in force until the transfer ends. These inputs give the beat width (byte, half-word or word), a per-address hold flag and step direction, the request mode, an 8-beat burst option, a bus-lock option and a unit count. In software mode the channel runs from start to finish by itself. In external-request mode it moves one unit for each request pulse it sees while it waits between units.

The bus side has two parts. One is a request/grant pair with a lock output. The other is a read/write strobe pair that shares one address and size bus and finishes on an acknowledge. Read data sits in the low bits of `mem_rdata`, and the same bits are driven on `mem_wdata`. At the end of a transfer the channel raises `done` and a level interrupt. Both stay high until `done_clr` is pulsed. A configuration that cannot be run sets `err` instead, and no bus cycle starts.

The controller has seven named states:
- `ST_IDLE` waits for `start`.
- `ST_WAIT_REQ` waits for an external request between units.
- `ST_RELEASE` drops the bus request for one cycle between unlocked units.
- `ST_ARB` asks for the bus until it is granted.
- `ST_READ` and `ST_WRITE` perform the two halves of a beat.
- `ST_FIN` sets `done`.

The transitions are:
- `ST_IDLE` goes to `ST_ARB` (software mode) or `ST_WAIT_REQ` (external mode) on a valid start.
- `ST_WAIT_REQ` goes to `ST_ARB` on a request, or straight to `ST_READ` if the bus is still held locked.
- `ST_RELEASE` always goes to `ST_ARB`.
- `ST_ARB` goes to `ST_READ` on grant.
- `ST_READ` goes to `ST_WRITE` on acknowledge.
- `ST_WRITE` goes to one of four places on acknowledge:
  - `ST_READ` if more beats remain in the unit, or if the bus is locked in software mode;
  - `ST_FIN` after the last unit;
  - `ST_WAIT_REQ` in external mode;
  - `ST_RELEASE` otherwise.
- `ST_FIN` always goes to `ST_IDLE`.

Top module: `xdma_channel`

## Requirements
- R1: `cfg_width` codes 00, 01 and 10 select 1, 2 and 4 bytes per beat. `mem_size` carries the latched code, and data of that size is copied in the low bits of the data buses.
- R2: A start pulse is refused, `err` is set and `busy` stays low in any of these cases: width code 11, mode code 10 or 11, or a source or destination base address not aligned to the width. A later accepted start clears `err`.
- R3: An address whose hold flag (`cfg_src_fixed` or `cfg_dst_fixed`) is 1 keeps its base value for every beat of the transfer.
- R4: An address that is not held moves by the beat size after each of its beats. It moves upward when its direction input is 0 and downward when it is 1.
- R5: With `cfg_burst` at 1, each count unit is 8 beats. With `cfg_burst` at 0, each unit is a single beat.
- R6: A start with `cfg_burst` at 1 and mode code 01 (external request) is refused and sets `err`.
- R7: In mode 01 the channel starts one unit for each cycle in which `ext_req` is high while it waits between units. A request raised while a unit is in progress is ignored.
- R8: With `cfg_lock` at 1, `bus_req` and `bus_lock` stay high from the first grant through the last write. With `cfg_lock` at 0, `bus_req` drops for at least one cycle between units.
- R9: After the last write is acknowledged, `done` and `irq` go high. They stay high until a cycle with `done_clr` at 1. Both are low after reset.
- R10: Each beat is a read followed by a write of the data just read. A strobe is only raised after the bus has been granted.
- R11: A start with `cfg_count` equal to 0 is refused and sets `err`.
- R12: A start pulse while `busy` is high is ignored, and the transfer in progress keeps its configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; captures the configuration inputs |
| cfg_width | input | 2 | Beat width code: 00 byte, 01 half-word, 10 word |
| cfg_mode | input | 2 | 00 software, 01 external request |
| cfg_src_fixed | input | 1 | Hold the source address |
| cfg_dst_fixed | input | 1 | Hold the destination address |
| cfg_src_down | input | 1 | Source steps downward when 1 |
| cfg_dst_down | input | 1 | Destination steps downward when 1 |
| cfg_burst | input | 1 | 8 beats per count unit |
| cfg_lock | input | 1 | Keep the bus for the whole transfer |
| cfg_src_addr | input | AW | Source base address |
| cfg_dst_addr | input | AW | Destination base address |
| cfg_count | input | CW | Number of units |
| ext_req | input | 1 | External transfer request |
| done_clr | input | 1 | Clears done and irq |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_lock | output | 1 | Bus held locked |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | AW | Beat address |
| mem_size | output | 2 | Beat width code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ack | input | 1 | Strobe acknowledge |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |
| irq | output | 1 | Level interrupt |
| err | output | 1 | Last start was refused |

## Verification
The assertions check several properties on every cycle:
- how each address register steps, holds or reloads;
- that a refused start leaves the channel idle with `err` set;
- that a write strobe only follows an acknowledged read;
- that a locked bus request never drops before the last write;
- that `done_clr` clears the flag and the interrupt only follows the last write.

Only the bench scenarios can show the following:
- the full copied data and address sequence under each width, direction, hold and burst setting;
- the number of bus request phases with and without lock;
- that an external request raised mid-unit is ignored;
- that a second start during a transfer changes nothing.

// File: rtl/xdma_pkg.sv
package xdma_pkg;

    localparam int XDMA_DW = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_RELEASE,
        ST_ARB,
        ST_READ,
        ST_WRITE,
        ST_FIN
    } xdma_state_e;

    localparam logic [1:0] W_BYTE   = 2'b00;
    localparam logic [1:0] W_HALF   = 2'b01;
    localparam logic [1:0] W_WORD   = 2'b10;
    localparam logic [1:0] M_SOFT   = 2'b00;
    localparam logic [1:0] M_EXTREQ = 2'b01;

    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        unique case (code)
            W_HALF:  return 3'd2;
            W_WORD:  return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [XDMA_DW-1:0] lane_mask(input logic [1:0] code);
        unique case (code)
            W_HALF:  return 32'h0000_FFFF;
            W_WORD:  return 32'hFFFF_FFFF;
            default: return 32'h0000_00FF;
        endcase
    endfunction

endpackage

// File: rtl/xdma_cfg_check.sv
module xdma_cfg_check
    import xdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic [1:0]    width,
    input  logic [1:0]    mode,
    input  logic          burst,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [CW-1:0] count,
    output logic          bad
);

    logic bad_width;
    logic bad_mode;
    logic bad_align;
    logic bad_burst;
    logic bad_count;

    always_comb begin
        bad_width = (width == 2'b11);
        bad_mode  = mode[1];
        unique case (width)
            W_HALF:  bad_align = src[0] | dst[0];
            W_WORD:  bad_align = (|src[1:0]) | (|dst[1:0]);
            default: bad_align = 1'b0;
        endcase
        bad_burst = burst && (mode == M_EXTREQ);
        bad_count = (count == '0);
        bad = bad_width | bad_mode | bad_align | bad_burst | bad_count;
    end

endmodule

// File: rtl/xdma_addr_gen.sv
module xdma_addr_gen #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          fixed_in,
    input  logic          down_in,
    input  logic          step,
    input  logic [2:0]    size_bytes,
    output logic [AW-1:0] addr
);

    logic          fixed_q;
    logic          down_q;
    logic [AW-1:0] inc;

    assign inc = {{(AW-3){1'b0}}, size_bytes};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr    <= '0;
            fixed_q <= 1'b0;
            down_q  <= 1'b0;
        end else if (load) begin
            addr    <= base;
            fixed_q <= fixed_in;
            down_q  <= down_in;
        end else if (step && !fixed_q) begin
            addr <= down_q ? (addr - inc) : (addr + inc);
        end
    end

    // R3: a held address does not move on a beat
    p_fixed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && fixed_q && !load) |=> $stable(addr));

    // R4: upward step by the beat size
    p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !fixed_q && !down_q && !load) |=> (addr == $past(addr) + $past(inc)));

    // R4: downward step by the beat size
    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !fixed_q && down_q && !load) |=> (addr == $past(addr) - $past(inc)));

endmodule

// File: rtl/xdma_fsm.sv
module xdma_fsm
    import xdma_pkg::*;
#(
    parameter int CW        = 16,
    parameter int BURST_LEN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cfg_bad,
    input  logic [1:0]    cfg_width,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_burst,
    input  logic          cfg_lock,
    input  logic [CW-1:0] cfg_count,
    input  logic          ext_req,
    input  logic          bus_gnt,
    input  logic          mem_ack,
    input  logic          done_clr,
    output logic          load,
    output logic          rd_step,
    output logic          wr_step,
    output logic          bus_req,
    output logic          bus_lock,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [1:0]    size_code,
    output logic [2:0]    size_bytes
);

    localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [BW-1:0] BEAT_LAST = BW'(BURST_LEN - 1);

    xdma_state_e   state_q, state_d;
    logic [CW-1:0] unit_left;
    logic [BW-1:0] beat_left;
    logic [1:0]    width_q;
    logic          ext_q, burst_q, lock_q, held_q, done_q, err_q;
    logic          last_unit;

    assign last_unit = (unit_left == CW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && !cfg_bad)
                    state_d = (cfg_mode == M_EXTREQ) ? ST_WAIT_REQ : ST_ARB;
            end
            ST_WAIT_REQ: begin
                if (ext_req) state_d = held_q ? ST_READ : ST_ARB;
            end
            ST_RELEASE: state_d = ST_ARB;
            ST_ARB: begin
                if (bus_gnt) state_d = ST_READ;
            end
            ST_READ: begin
                if (mem_ack) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    if (beat_left != '0)  state_d = ST_READ;
                    else if (last_unit)   state_d = ST_FIN;
                    else if (ext_q)       state_d = ST_WAIT_REQ;
                    else if (lock_q)      state_d = ST_READ;
                    else                  state_d = ST_RELEASE;
                end
            end
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // counters, latched configuration and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_left <= '0;
            beat_left <= '0;
            width_q   <= W_BYTE;
            ext_q     <= 1'b0;
            burst_q   <= 1'b0;
            lock_q    <= 1'b0;
            held_q    <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (done_clr) done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (cfg_bad) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q     <= 1'b0;
                            width_q   <= cfg_width;
                            ext_q     <= (cfg_mode == M_EXTREQ);
                            burst_q   <= cfg_burst;
                            lock_q    <= cfg_lock;
                            unit_left <= cfg_count;
                            beat_left <= cfg_burst ? BEAT_LAST : '0;
                        end
                    end
                end
                ST_ARB: begin
                    if (bus_gnt) held_q <= lock_q;
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        if (beat_left != '0) begin
                            beat_left <= beat_left - BW'(1);
                        end else begin
                            unit_left <= unit_left - CW'(1);
                            beat_left <= burst_q ? BEAT_LAST : '0;
                            if (last_unit) held_q <= 1'b0;
                        end
                    end
                end
                ST_FIN:  done_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        load       = (state_q == ST_IDLE) && start && !cfg_bad;
        mem_rd     = (state_q == ST_READ);
        mem_wr     = (state_q == ST_WRITE);
        rd_step    = mem_rd && mem_ack;
        wr_step    = mem_wr && mem_ack;
        bus_req    = held_q || (state_q == ST_ARB) || mem_rd || mem_wr;
        bus_lock   = held_q;
        busy       = (state_q != ST_IDLE);
        done       = done_q;
        err        = err_q;
        size_code  = width_q;
        size_bytes = width_bytes(width_q);
    end

    // R2 / R6: a refused start leaves the channel idle with err set
    p_refuse_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cfg_bad) |=> (!busy && err));

    // R11: a zero count is refused
    p_zero_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cfg_count == '0) |=> err);

    // R10: a write strobe only begins after an acknowledged read
    p_write_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |-> $past(mem_rd && mem_ack));

    // R8: a locked request never drops before the last write
    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && !(mem_wr && mem_ack)) |=> bus_req);

    // R7: no read begins while waiting without a request
    p_ext_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_REQ && !ext_req) |=> !mem_rd);

    // R9: done_clr clears the flag unless the transfer is finishing
    p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && state_q != ST_FIN) |=> !done);

endmodule

// File: rtl/xdma_channel.sv
module xdma_channel
    import xdma_pkg::*;
#(
    parameter int AW        = 16,
    parameter int CW        = 16,
    parameter int BURST_LEN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cfg_width,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_src_fixed,
    input  logic          cfg_dst_fixed,
    input  logic          cfg_src_down,
    input  logic          cfg_dst_down,
    input  logic          cfg_burst,
    input  logic          cfg_lock,
    input  logic [AW-1:0] cfg_src_addr,
    input  logic [AW-1:0] cfg_dst_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic          ext_req,
    input  logic          done_clr,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_lock,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    output logic          busy,
    output logic          done,
    output logic          irq,
    output logic          err
);

    localparam int NPTR = 2;   // index 0 source, index 1 destination

    logic                    cfg_bad;
    logic                    load, rd_step, wr_step;
    logic [2:0]              size_bytes;
    logic [1:0]              size_code;
    logic [NPTR-1:0][AW-1:0] base_a, cur_a;
    logic [NPTR-1:0]         step_a, fix_a, down_a;
    logic [XDMA_DW-1:0]      data_q;

    xdma_cfg_check #(.AW(AW), .CW(CW)) u_check (
        .width (cfg_width),
        .mode  (cfg_mode),
        .burst (cfg_burst),
        .src   (cfg_src_addr),
        .dst   (cfg_dst_addr),
        .count (cfg_count),
        .bad   (cfg_bad)
    );

    xdma_fsm #(.CW(CW), .BURST_LEN(BURST_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_bad    (cfg_bad),
        .cfg_width  (cfg_width),
        .cfg_mode   (cfg_mode),
        .cfg_burst  (cfg_burst),
        .cfg_lock   (cfg_lock),
        .cfg_count  (cfg_count),
        .ext_req    (ext_req),
        .bus_gnt    (bus_gnt),
        .mem_ack    (mem_ack),
        .done_clr   (done_clr),
        .load       (load),
        .rd_step    (rd_step),
        .wr_step    (wr_step),
        .bus_req    (bus_req),
        .bus_lock   (bus_lock),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .size_code  (size_code),
        .size_bytes (size_bytes)
    );

    assign base_a = {cfg_dst_addr, cfg_src_addr};
    assign fix_a  = {cfg_dst_fixed, cfg_src_fixed};
    assign down_a = {cfg_dst_down, cfg_src_down};
    assign step_a = {wr_step, rd_step};

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        xdma_addr_gen #(.AW(AW)) u_addr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .base       (base_a[g]),
            .fixed_in   (fix_a[g]),
            .down_in    (down_a[g]),
            .step       (step_a[g]),
            .size_bytes (size_bytes),
            .addr       (cur_a[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_q <= '0;
        else if (rd_step) data_q <= mem_rdata & lane_mask(size_code);
    end

    assign mem_addr  = mem_wr ? cur_a[1] : cur_a[0];
    assign mem_size  = size_code;
    assign mem_wdata = data_q;
    assign irq       = done;

    // R9: the interrupt only rises two cycles after the last write acknowledge
    p_irq_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_wr && mem_ack, 2));

    // R12: a start while busy never reloads the pointers
    p_busy_no_reload_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !rd_step && !wr_step) |=> ($stable(cur_a) && busy));

endmodule

// File: tb/test_xdma_channel.sv
module test_xdma_channel;

    localparam int AW = 16;
    localparam int CW = 16;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [1:0]    s;
        logic [31:0]   d;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    cfg_width = 2'b00, cfg_mode = 2'b00;
    logic          cfg_src_fixed = 1'b0, cfg_dst_fixed = 1'b0;
    logic          cfg_src_down = 1'b0, cfg_dst_down = 1'b0;
    logic          cfg_burst = 1'b0, cfg_lock = 1'b0;
    logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          ext_req = 1'b0, done_clr = 1'b0;
    logic          bus_req, bus_lock, mem_rd, mem_wr;
    logic          bus_gnt = 1'b0, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          busy, done, irq, err;

    logic [7:0] mem [0:1023];
    item_t      exp_q [$];
    int         checks = 0, fails = 0;
    int         writes = 0, req_rises = 0, cyc = 0;
    logic       prev_req = 1'b0, lock_seen = 1'b0;
    string      cur_req = "R1";

    always #2 clk = ~clk;

    xdma_channel #(.AW(AW), .CW(CW)) i_xdma_channel (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_mem(input logic [AW-1:0] a, input logic [1:0] s);
        logic [31:0] v = '0;
        int n = (s == 2'b10) ? 4 : (s == 2'b01) ? 2 : 1;
        for (int b = 0; b < n; b++) v[8*b +: 8] = mem[(int'(a) + b) % 1024];
        return v;
    endfunction

    // bus responder and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_gnt <= 1'b0;
            mem_ack <= 1'b0;
            prev_req <= 1'b0;
        end else begin
            bus_gnt  <= bus_req;
            prev_req <= bus_req;
            if (bus_req && !prev_req) req_rises++;
            if (bus_lock) lock_seen <= 1'b1;
            if ((mem_rd || mem_wr) && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_rd) begin
                    mem_rdata <= rd_mem(mem_addr, mem_size);
                end else begin
                    item_t e;
                    int n = (mem_size == 2'b10) ? 4 : (mem_size == 2'b01) ? 2 : 1;
                    writes++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, cur_req, "unexpected write addr", longint'(mem_addr), 0);
                    end else begin
                        e = exp_q.pop_front();
                        check({mem_addr, mem_size, mem_wdata} == e, cur_req,
                              "write addr/size/data", longint'({mem_addr, mem_size, mem_wdata}),
                              longint'(e));
                    end
                    for (int b = 0; b < n; b++) mem[(int'(mem_addr) + b) % 1024] = mem_wdata[8*b +: 8];
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic init_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 13 + 5);
    endtask

    // driver: set configuration, push expected writes, pulse start
    task automatic run_xfer(input logic [1:0] w, input logic [1:0] m, input bit sf, input bit df,
                            input bit sd, input bit dd, input bit bu, input bit lk,
                            input logic [AW-1:0] s, input logic [AW-1:0] d, input int cnt,
                            input bit expect_ok);
        int  step = (w == 2'b10) ? 4 : (w == 2'b01) ? 2 : 1;
        logic [AW-1:0] sa = s, da = d;
        init_mem();
        writes = 0; req_rises = 0; lock_seen = 1'b0;
        if (expect_ok) begin
            for (int i = 0; i < cnt * (bu ? 8 : 1); i++) begin
                exp_q.push_back({da, w, rd_mem(sa, w)});
                if (!sf) sa = sd ? sa - AW'(step) : sa + AW'(step);
                if (!df) da = dd ? da - AW'(step) : da + AW'(step);
            end
        end
        @(negedge clk);
        cfg_width = w; cfg_mode = m; cfg_src_fixed = sf; cfg_dst_fixed = df;
        cfg_src_down = sd; cfg_dst_down = dd; cfg_burst = bu; cfg_lock = lk;
        cfg_src_addr = s; cfg_dst_addr = d; cfg_count = CW'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, req, "done raised", done, 1);
        check(exp_q.size() == 0, req, "all expected writes seen", exp_q.size(), 0);
    endtask

    task automatic clear_done();
        @(negedge clk) done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
    endtask

    task automatic refuse(input string req, input logic [1:0] w, input logic [1:0] m,
                          input bit bu, input logic [AW-1:0] s, input logic [AW-1:0] d, input int cnt);
        cur_req = req;
        run_xfer(w, m, 0, 0, 0, 0, bu, 0, s, d, cnt, 0);
        repeat (10) @(negedge clk);
        check(err == 1'b1, req, "err after refused start", err, 1);
        check(busy == 1'b0 && bus_req == 1'b0, req, "idle after refused start", {busy, bus_req}, 0);
        check(writes == 0, req, "no writes", writes, 0);
    endtask

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        // R9 reset state
        check({busy, done, irq, err, bus_req, mem_rd, mem_wr} == 7'b0, "R9", "reset outputs",
              {busy, done, irq, err, bus_req, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 byte, half, word with upward steps (R10 data copy checked by scoreboard)
        cur_req = "R1";
        run_xfer(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 16'h0101, 16'h0201, 5, 1);
        wait_done("R1"); check(writes == 5, "R1", "byte beats", writes, 5); clear_done();
        run_xfer(2'b01, 2'b00, 0, 0, 0, 0, 0, 0, 16'h0102, 16'h0206, 4, 1);
        wait_done("R1"); clear_done();
        cur_req = "R10";
        run_xfer(2'b10, 2'b00, 0, 0, 0, 0, 0, 0, 16'h0104, 16'h0208, 3, 1);
        wait_done("R10"); clear_done();

        // R3 held source, then held destination
        cur_req = "R3";
        run_xfer(2'b10, 2'b00, 1, 0, 0, 0, 0, 0, 16'h0110, 16'h0240, 3, 1);
        wait_done("R3"); clear_done();
        run_xfer(2'b01, 2'b00, 0, 1, 0, 0, 0, 0, 16'h0120, 16'h0250, 4, 1);
        wait_done("R3"); clear_done();

        // R4 both downward, and mixed directions
        cur_req = "R4";
        run_xfer(2'b01, 2'b00, 0, 0, 1, 1, 0, 0, 16'h0140, 16'h0280, 4, 1);
        wait_done("R4"); clear_done();
        run_xfer(2'b10, 2'b00, 0, 0, 1, 0, 0, 0, 16'h0160, 16'h02A0, 3, 1);
        wait_done("R4"); clear_done();

        // R5 burst: 2 units of 8 beats
        cur_req = "R5";
        run_xfer(2'b10, 2'b00, 0, 0, 0, 0, 1, 0, 16'h0000, 16'h0300, 2, 1);
        wait_done("R5"); check(writes == 16, "R5", "burst beats", writes, 16); clear_done();

        // R8 locked vs unlocked bus request phases
        cur_req = "R8";
        run_xfer(2'b00, 2'b00, 0, 0, 0, 0, 0, 1, 16'h0180, 16'h0380, 3, 1);
        wait_done("R8");
        check(req_rises == 1, "R8", "locked request phases", req_rises, 1);
        check(lock_seen == 1'b1, "R8", "bus_lock seen", lock_seen, 1);
        check(bus_req == 1'b0 && bus_lock == 1'b0, "R8", "bus released at end", {bus_req, bus_lock}, 0);
        clear_done();
        run_xfer(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 16'h0180, 16'h0380, 3, 1);
        wait_done("R8");
        check(req_rises == 3, "R8", "unlocked request phases", req_rises, 3);
        check(lock_seen == 1'b0, "R8", "no lock when clear", lock_seen, 0);

        // R9 interrupt level and clear
        repeat (5) @(negedge clk);
        check(irq == 1'b1 && done == 1'b1, "R9", "irq held", {irq, done}, 3);
        clear_done();
        check(irq == 1'b0 && done == 1'b0, "R9", "irq cleared", {irq, done}, 0);

        // refused starts
        refuse("R2", 2'b11, 2'b00, 0, 16'h0100, 16'h0200, 2);
        refuse("R2", 2'b00, 2'b10, 0, 16'h0100, 16'h0200, 2);
        refuse("R2", 2'b10, 2'b00, 0, 16'h0102, 16'h0200, 2);
        refuse("R2", 2'b01, 2'b00, 0, 16'h0100, 16'h0201, 2);
        refuse("R6", 2'b10, 2'b01, 1, 16'h0100, 16'h0200, 1);
        refuse("R11", 2'b00, 2'b00, 0, 16'h0100, 16'h0200, 0);

        // R7 external request mode (also clears err per R2)
        cur_req = "R7";
        run_xfer(2'b10, 2'b01, 0, 0, 0, 0, 0, 0, 16'h0040, 16'h03C0, 2, 1);
        check(err == 1'b0, "R2", "err cleared by accepted start", err, 0);
        repeat (20) @(negedge clk);
        check(writes == 0 && bus_req == 1'b0, "R7", "waits for request", writes, 0);
        ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
        repeat (2) @(negedge clk);
        ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;   // mid-unit, ignored
        repeat (30) @(negedge clk);
        check(writes == 1, "R7", "one unit per request", writes, 1);
        check(done == 1'b0, "R7", "not done after one unit", done, 0);
        ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
        wait_done("R7"); check(writes == 2, "R7", "second unit", writes, 2); clear_done();

        // R12 start while busy is ignored
        cur_req = "R12";
        run_xfer(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 16'h01C0, 16'h03E0, 4, 1);
        repeat (4) @(negedge clk);
        cfg_width = 2'b10; cfg_src_fixed = 1'b1; cfg_src_addr = 16'h0000; cfg_count = 16'd1;
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done("R12");
        check(writes == 4 && err == 1'b0, "R12", "original transfer kept", writes, 4);
        clear_done();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule